// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Adaptive Dead Time

This block drives the two switches of a half bridge from a digital sawtooth timebase. The timebase counts clock cycles up to a commanded period and then wraps. One ramp period equals one half-cycle of the bridge, so the ramp runs at twice the bridge frequency. In each half-cycle, exactly one switch conducts, and the two switches take turns. Each half-cycle opens with a non-overlap interval in which both gate enables are low. That interval closes as soon as a deglitched switch-node slope indication arrives, but never before a fixed minimum. If no slope arrives, the interval is cut off at half a ramp period, which is one quarter of the bridge period.

Operation begins with a start pulse while the block is enabled. The first switch to conduct is always the low-side one. Its first conduction is stretched over several ramp periods so that the high-side bootstrap supply can charge. Dropping the enable returns the block to an idle state with both gates low. A new frequency command is taken only at a ramp wrap, so a half-cycle that is already running keeps its length.

Top module: `hbd_gate_seq`

## Requirements
- R1: After reset both `gate_lo` and `gate_hi` are low. In the cycle after `enable` is sampled low, both outputs are low. A `start` pulse while `enable` is low leaves both outputs low.
- R2: `gate_lo` and `gate_hi` are never high in the same cycle. Every change from one gate to the other passes through at least MIN_DT cycles with both gates low.
- R3: A `start` pulse sampled with `enable` high in the idle state raises `gate_lo` after that clock edge. `gate_lo` then stays high for BOOT_RAMPS full ramp periods.
- R4: After the stretched first phase, half-cycles alternate in the order high-side, low-side, high-side, and so on. A half-cycle of latched period P with dead interval k holds its gate high for P-k cycles.
- R5: When the filtered slope indication is high, the dead interval ends at the first cycle that is at least MIN_DT cycles long. A raw slope that rises at the start of the dead interval gives an interval of max(MIN_DT, FILT_LEN+1) cycles.
- R6: With no slope indication, the dead interval lasts floor(P/2) cycles, which is 25 % of the bridge period of 2P.
- R7: A raw slope pulse held for fewer than FILT_LEN consecutive clock edges is ignored. The dead interval then runs to the R6 limit.
- R8: `period_cmd` is latched only at a ramp wrap (and at start). A change in the middle of a half-cycle therefore first affects the next half-cycle. Values below 4*MIN_DT are raised to 4*MIN_DT.
- R9: A `start` pulse while the block is already running has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run permission; low forces idle with both gates off |
| start | input | 1 | Single-cycle start request |
| period_cmd | input | CNT_W | Ramp period in clock cycles (one bridge half-cycle) |
| slope_raw | input | 1 | Unfiltered switch-node slope-detect indication |
| gate_lo | output | 1 | Low-side gate enable |
| gate_hi | output | 1 | High-side gate enable |

## Verification
The assertions assume that `period_cmd` never falls below the clamp. They also assume that the latched period is never shorter than the minimum dead interval plus one cycle of conduction, which the clamp at 4*MIN_DT guarantees. They further assume that `slope_raw` is a level that the bench sets and clears between clock edges. The stimulus updates `period_cmd` only when a conduction phase begins. It raises or lowers the raw slope only at phase boundaries, or after a counted number of edges for the glitch case. As a result, each expected dead length and conduction length follows directly from the period of that half-cycle and from the slope pattern chosen for it.

// File: rtl/hbd_pkg.sv
`timescale 1ns/1ps
package hbd_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LO    = 3'd1,
        PH_DT_HI = 3'd2,
        PH_HI    = 3'd3,
        PH_DT_LO = 3'd4
    } phase_e;
endpackage

// File: rtl/hbd_deglitch.sv
`timescale 1ns/1ps
module hbd_deglitch #(
    parameter int LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = (LEN < 2) ? 1 : $clog2(LEN + 1);

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (raw != f_q.filt) begin
            if (f_q.cnt == CW'(LEN - 1)) begin
                f_d.filt = raw;
                f_d.cnt  = '0;
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end else begin
            f_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign filt = f_q.filt;

    AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.filt != $past(f_q.filt)) |-> ($past(raw) == f_q.filt)); // R7
    AST_FILT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt < CW'(LEN)); // R7
endmodule

// File: rtl/hbd_ramp.sv
`timescale 1ns/1ps
module hbd_ramp #(
    parameter int CNT_W   = 10,
    parameter int PER_MIN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] period_cmd,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] period,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] PMIN = CNT_W'(PER_MIN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
    } ramp_t;

    ramp_t r_d, r_q;
    logic [CNT_W-1:0] per_clamped;

    always_comb begin
        per_clamped = (period_cmd < PMIN) ? PMIN : period_cmd;
        wrap        = run && (r_q.cnt == r_q.per - 1'b1);
        r_d         = r_q;
        if (restart) begin
            r_d.cnt = '0;
            r_d.per = per_clamped;
        end else if (run) begin
            if (wrap) begin
                r_d.cnt = '0;
                r_d.per = per_clamped;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
            r_q.per <= PMIN;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt    = r_q.cnt;
    assign period = r_q.per;

    AST_RAMP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < r_q.per); // R8
    AST_PERIOD_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.per >= PMIN); // R8
    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt != '0) |-> $stable(r_q.per)); // R8
endmodule

// File: rtl/hbd_gate_seq.sv
`timescale 1ns/1ps
module hbd_gate_seq #(
    parameter int CNT_W      = 10,
    parameter int FILT_LEN   = 6,
    parameter int MIN_DT     = 4,
    parameter int BOOT_RAMPS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [CNT_W-1:0] period_cmd,
    input  logic             slope_raw,
    output logic             gate_lo,
    output logic             gate_hi
);
    import hbd_pkg::*;

    localparam int PER_MIN = 4 * MIN_DT;
    localparam int BOOT_W  = (BOOT_RAMPS < 2) ? 1 : $clog2(BOOT_RAMPS + 1);
    localparam logic [CNT_W-1:0] MIN_DT_C = CNT_W'(MIN_DT);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  dt;
        logic [BOOT_W-1:0] boot;
        logic              g_lo;
        logic              g_hi;
    } seq_t;

    seq_t s_d, s_q;

    logic             slope_f;
    logic             wrap;
    logic             restart;
    logic             run;
    logic [CNT_W-1:0] ramp_cnt;
    logic [CNT_W-1:0] ramp_per;
    logic [CNT_W-1:0] dt_max;
    logic [CNT_W-1:0] dt_next;
    logic             dt_done;

    hbd_deglitch #(.LEN(FILT_LEN)) u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (slope_raw),
        .filt  (slope_f)
    );

    hbd_ramp #(.CNT_W(CNT_W), .PER_MIN(PER_MIN)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .restart    (restart),
        .period_cmd (period_cmd),
        .cnt        (ramp_cnt),
        .period     (ramp_per),
        .wrap       (wrap)
    );

    always_comb begin
        restart = (s_q.ph == PH_IDLE) && enable && start;
        run     = (s_q.ph != PH_IDLE);
        dt_max  = ramp_per >> 1;
        dt_next = s_q.dt + 1'b1;
        dt_done = ((dt_next >= MIN_DT_C) && slope_f) || (dt_next >= dt_max);

        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (restart) begin
                    s_d.ph   = PH_LO;
                    s_d.boot = BOOT_W'(BOOT_RAMPS - 1);
                end
            end
            PH_LO: begin
                if (wrap) begin
                    if (s_q.boot != '0) begin
                        s_d.boot = s_q.boot - 1'b1;
                    end else begin
                        s_d.ph = PH_DT_HI;
                        s_d.dt = '0;
                    end
                end
            end
            PH_DT_HI: begin
                if (dt_done) s_d.ph = PH_HI;
                else         s_d.dt = dt_next;
            end
            PH_HI: begin
                if (wrap) begin
                    s_d.ph = PH_DT_LO;
                    s_d.dt = '0;
                end
            end
            PH_DT_LO: begin
                if (dt_done) s_d.ph = PH_LO;
                else         s_d.dt = dt_next;
            end
            default: s_d.ph = PH_IDLE;
        endcase

        if (!enable) begin
            s_d.ph   = PH_IDLE;
            s_d.dt   = '0;
            s_d.boot = '0;
        end

        s_d.g_lo = (s_d.ph == PH_LO);
        s_d.g_hi = (s_d.ph == PH_HI);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph   <= PH_IDLE;
            s_q.dt   <= '0;
            s_q.boot <= '0;
            s_q.g_lo <= 1'b0;
            s_q.g_hi <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_lo = s_q.g_lo;
    assign gate_hi = s_q.g_hi;

    // Both-low run length, kept only for the checks below.
    logic [CNT_W-1:0] lowrun_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          lowrun_q <= '0;
        else if (gate_lo || gate_hi)         lowrun_q <= '0;
        else if (lowrun_q != {CNT_W{1'b1}})  lowrun_q <= lowrun_q + 1'b1;
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_lo && gate_hi)); // R2
    AST_DEAD_BEFORE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> (lowrun_q >= MIN_DT_C)); // R2
    AST_DEAD_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_lo) && ($past(s_q.ph) != PH_IDLE)) |-> (lowrun_q >= MIN_DT_C)); // R2
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate_lo && !gate_hi)); // R1
    AST_FIRST_IS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(s_q.ph) == PH_IDLE) && (s_q.ph != PH_IDLE)) |-> gate_lo); // R3
    AST_DT_UNDER_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.ph == PH_DT_HI) || (s_q.ph == PH_DT_LO)) |-> (s_q.dt < dt_max)); // R6
    AST_GATE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_hi) && enable) |-> (ramp_cnt == '0)); // R4
endmodule

// File: tb/sim_hbd_gate_seq.sv
`timescale 1ns/1ps
module sim_hbd_gate_seq;
    localparam int CNT_W      = 10;
    localparam int FILT_LEN   = 6;
    localparam int MIN_DT     = 4;
    localparam int BOOT_RAMPS = 3;
    localparam int NV         = 10;

    // period_cmd, slope mode, expected dead, expected conduction
    // modes: 0 none, 1 held high, 2 rises at dead start, 3 short glitch
    localparam int VEC [0:NV-1][0:3] = '{
        '{40, 0, 20, 20},
        '{40, 2,  7, 33},
        '{40, 1,  4, 36},
        '{64, 3, 32, 32},
        '{64, 2,  7, 57},
        '{ 5, 0,  8,  8},
        '{16, 2,  7,  9},
        '{33, 1,  4, 29},
        '{33, 0, 16, 17},
        '{20, 3, 10, 10}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] period_cmd = '0;
    logic             slope_raw = 1'b0;
    logic             gate_lo, gate_hi;

    int checks = 0;
    int fails  = 0;
    int overlap = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    hbd_gate_seq #(.CNT_W(CNT_W), .FILT_LEN(FILT_LEN), .MIN_DT(MIN_DT),
                   .BOOT_RAMPS(BOOT_RAMPS)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .period_cmd(period_cmd), .slope_raw(slope_raw),
        .gate_lo(gate_lo), .gate_hi(gate_hi)
    );

    always @(negedge clk) if (gate_lo && gate_hi) overlap++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts samples while the gate seen now stays the only one high.
    task automatic count_on(output int n);
        logic hi_now;
        hi_now = gate_hi;
        n = 0;
        while ((gate_lo ^ gate_hi) && (gate_hi == hi_now) && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_dead(input int mode, output int n);
        n = 0;
        if (mode == 2 || mode == 3) slope_raw = 1'b1;
        while (!gate_lo && !gate_hi && n < 4000) begin
            n++;
            if (mode == 3 && n == FILT_LEN) slope_raw = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        int m;
        string tag;
        repeat (3) @(negedge clk);
        chk("R1 reset lo", int'(gate_lo), 0);
        chk("R1 reset hi", int'(gate_hi), 0);
        rst_n = 1'b1;
        period_cmd = CNT_W'(VEC[0][0]);

        // start while disabled is ignored
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);
        chk("R1 start while disabled", int'({gate_lo, gate_hi}), 0);

        enable = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 enabled without start", int'({gate_lo, gate_hi}), 0);

        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R3 first gate is low side", int'({gate_lo, gate_hi}), 2);

        for (int i = 0; i < NV; i++) begin
            period_cmd = CNT_W'(VEC[i][0]);
            slope_raw  = (VEC[i][1] == 1);
            count_on(n);
            if (i == 0) chk("R3 stretched first conduction", n, BOOT_RAMPS * VEC[0][0]);
            else if (VEC[i][0] != VEC[i-1][0]) chk("R8 old period kept mid-cycle", n, VEC[i-1][3]);
            else chk("R4 conduction length", n, VEC[i-1][3]);
            count_dead(VEC[i][1], n);
            case (VEC[i][1])
                0: tag = (i == 5) ? "R8 clamped period dead" : "R6 no slope dead";
                3: tag = "R7 glitch ignored dead";
                default: tag = "R5 slope ends dead";
            endcase
            chk(tag, n, VEC[i][2]);
            chk("R4 alternation", int'({gate_lo, gate_hi}), (i % 2 == 0) ? 1 : 2);
        end

        // R9: start pulse during a running conduction has no effect
        slope_raw = 1'b0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        count_on(m);
        chk("R9 start while running, conduction", m + 1, VEC[NV-1][3]);
        count_dead(0, n);
        chk("R9 start while running, dead", n, VEC[NV-1][0] / 2);

        // R1: disable mid-conduction
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R1 disable forces off", int'({gate_lo, gate_hi}), 0);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        chk("R1 stays off while disabled", int'({gate_lo, gate_hi}), 0);

        chk("R2 never both high", overlap, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule